// File: doc/BRIEF.md
# Dadda-Reduction Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (default 8) and returns their full product of `2*WIDTH` bits. It is purely combinational: there is no clock, no reset and no handshake. A change on either operand reaches the product within the same evaluation, so the caller decides where the registers go.

Internally, an AND array forms one partial-product bit for every pair of operand bits. A reduction network then compresses these columns to two rows. It works against a fixed ladder of column-height limits, which starts at 2 and grows by taking the floor of one and a half times the previous limit: 2, 3, 4, 6, 9, 13 and so on. The network steps down that ladder from the largest limit that is still below the operand width.

Within each step, a column gets full adders (three bits into two) and at most one half adder (two bits into two). These are placed only while the column's remaining bits, plus the carries arriving from the column below, exceed the limit. A sum stays in its own column, and a carry moves one column up. A ripple carry-propagate adder then sums the two surviving rows. The carry out of the top bit is always zero and is discarded.

Top module: `dadda_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals `opa * opb` computed over `2*WIDTH` bits.
- R2: The stage limit function returns 2 for stage 1, and for each later stage it returns the floor of 1.5 times the previous limit. The first six values are 2, 3, 4, 6, 9, 13.
- R3: For an 8-bit operand width, the reduction uses exactly four stages, with limits 6, 4, 3 and 2 in that order.
- R4: If either operand is zero, `prod` is zero.
- R5: With both operands at their maximum of all ones, `prod` equals (2^WIDTH-1)^2 with no bit lost. For `WIDTH`=8 this is 16'hFE01.
- R6: If one operand is a power of two 2^k, `prod` equals the other operand shifted left by k.
- R7: The block holds no state. `prod` follows a change of the operands without any clock edge, and two equal operand pairs applied at different times give equal products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Unsigned multiplicand |
| opb | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Unsigned full-width product |

## Verification
The hardest case to reach is the one where the half adder in a stage fires. It fires only when a column's height plus its incoming carries exceeds the limit by exactly one. It also only shows a fault when carries ripple through the high columns, and that takes dense operands with many ones in both. Instead of relying on chosen patterns to reach these cases, the bench sweeps every one of the 65536 operand pairs at the default width. This drives every adder cell and every carry path with both input values. It then revisits a few operand pairs with no clock running, to show that the product tracks its inputs directly.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  // Height limit of reduction stage k (k = 1 is the last, two-row stage).
  function automatic int dadda_limit(input int k);
    int d;
    d = 2;
    for (int j = 1; j < k; j++) d = (d * 3) / 2;
    return d;
  endfunction

  // Number of stages needed so that every limit used is below the start height.
  function automatic int dadda_stages(input int start_h);
    int s;
    s = 0;
    for (int j = 1; j < 32; j++) begin
      if (dadda_limit(j) < start_h) s = j;
    end
    return s;
  endfunction

endpackage

// File: rtl/dadda_ppgen.sv
module dadda_ppgen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] pp_row [WIDTH]
);
  // Row j holds opa AND opb[j]; its bit i lands in column i+j.
  for (genvar j = 0; j < WIDTH; j++) begin : g_row
    assign pp_row[j] = opa & {WIDTH{opb[j]}};
  end
endmodule

// File: rtl/dadda_reduce.sv
module dadda_reduce
  import dadda_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   pp_row [WIDTH],
  output logic [2*WIDTH-1:0] row_x,
  output logic [2*WIDTH-1:0] row_y
);
  localparam int COLS   = 2 * WIDTH;
  localparam int HMAX   = WIDTH;
  localparam int STAGES = dadda_stages(WIDTH);

  logic [HMAX-1:0] cur [COLS];
  logic [HMAX-1:0] nxt [COLS];
  int              cur_h [COLS];
  int              nxt_h [COLS];

  always_comb begin
    // Load the matrix, column by column, from the partial-product rows.
    for (int c = 0; c < COLS; c++) begin
      cur[c]   = '0;
      cur_h[c] = 0;
    end
    for (int j = 0; j < WIDTH; j++) begin
      for (int i = 0; i < WIDTH; i++) begin
        cur[i+j][cur_h[i+j]] = pp_row[j][i];
        cur_h[i+j]           = cur_h[i+j] + 1;
      end
    end

    // Walk down the ladder of limits, compressing only what each stage needs.
    for (int s = STAGES; s >= 1; s--) begin
      for (int c = 0; c < COLS; c++) begin
        nxt[c]   = '0;
        nxt_h[c] = 0;
      end
      for (int c = 0; c < COLS; c++) begin
        int p;
        p = 0;
        for (int k = 0; k < HMAX; k++) begin
          int excess;
          excess = (cur_h[c] - p) + nxt_h[c] - dadda_limit(s);
          if (excess >= 2 && (cur_h[c] - p) >= 3) begin
            // full adder: three bits of column c into sum(c) and carry(c+1)
            nxt[c][nxt_h[c]] = cur[c][p] ^ cur[c][p+1] ^ cur[c][p+2];
            nxt_h[c]         = nxt_h[c] + 1;
            if (c + 1 < COLS) begin
              nxt[c+1][nxt_h[c+1]] = (cur[c][p] & cur[c][p+1]) |
                                     (cur[c][p+2] & (cur[c][p] ^ cur[c][p+1]));
              nxt_h[c+1]           = nxt_h[c+1] + 1;
            end
            p = p + 3;
          end else if (excess >= 1 && (cur_h[c] - p) >= 2) begin
            // half adder: two bits into sum(c) and carry(c+1)
            nxt[c][nxt_h[c]] = cur[c][p] ^ cur[c][p+1];
            nxt_h[c]         = nxt_h[c] + 1;
            if (c + 1 < COLS) begin
              nxt[c+1][nxt_h[c+1]] = cur[c][p] & cur[c][p+1];
              nxt_h[c+1]           = nxt_h[c+1] + 1;
            end
            p = p + 2;
          end
        end
        // Bits left untouched pass straight to the next stage.
        for (int k = 0; k < HMAX; k++) begin
          if (k >= p && k < cur_h[c]) begin
            nxt[c][nxt_h[c]] = cur[c][k];
            nxt_h[c]         = nxt_h[c] + 1;
          end
        end
      end
      for (int c = 0; c < COLS; c++) begin
        cur[c]   = nxt[c];
        cur_h[c] = nxt_h[c];
      end
    end

    for (int c = 0; c < COLS; c++) begin
      row_x[c] = cur[c][0];
      row_y[c] = cur[c][1];
    end
  end
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
  parameter int BITS = 16
) (
  input  logic [BITS-1:0] x,
  input  logic [BITS-1:0] y,
  output logic [BITS-1:0] sum
);
  logic [BITS:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end
  // carry[BITS] is never set for a valid product and is left unused.
  logic unused_top;
  assign unused_top = carry[BITS];
endmodule

// File: rtl/dadda_mult.sv
module dadda_mult #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] pp_row [WIDTH];
  logic [PW-1:0]    row_x;
  logic [PW-1:0]    row_y;

  dadda_ppgen #(.WIDTH(WIDTH)) u_ppgen (
    .opa    (opa),
    .opb    (opb),
    .pp_row (pp_row)
  );

  dadda_reduce #(.WIDTH(WIDTH)) u_reduce (
    .pp_row (pp_row),
    .row_x  (row_x),
    .row_y  (row_y)
  );

  dadda_cpa #(.BITS(PW)) u_cpa (
    .x   (row_x),
    .y   (row_y),
    .sum (prod)
  );
endmodule

// File: rtl/dadda_mult_chk.sv
module dadda_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]   opa,
  input logic [WIDTH-1:0]   opb,
  input logic [2*WIDTH-1:0] prod,
  input logic [2*WIDTH-1:0] row_x,
  input logic [2*WIDTH-1:0] row_y
);
  localparam int PW = 2 * WIDTH;
  logic [PW-1:0] ref_prod;
  logic [PW-1:0] max_prod;
  assign ref_prod = PW'(opa) * PW'(opb);
  assign max_prod = PW'({WIDTH{1'b1}}) * PW'({WIDTH{1'b1}});

  always_comb begin
    if (!$isunknown({opa, opb, prod, row_x, row_y})) begin
      assert_product_R1: assert (prod == ref_prod);
      assert_rows_sum_R1: assert ((row_x + row_y) == ref_prod);
      assert_zero_operand_R4: assert (!(opa == '0 || opb == '0) || prod == '0);
      assert_no_overflow_R5: assert (prod <= max_prod);
      assert_unit_operand_R6: assert (opb != PW'(1) || prod == PW'(opa));
    end
  end
endmodule

bind dadda_mult dadda_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .opa   (opa),
  .opb   (opb),
  .prod  (prod),
  .row_x (row_x),
  .row_y (row_y)
);

// File: tb/tb_dadda_mult.sv
`timescale 1ns/1ps
module tb_dadda_mult;
  import dadda_pkg::*;

  localparam int WIDTH = 8;
  localparam int PW    = 2 * WIDTH;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [WIDTH-1:0] opa, opb;
  logic [PW-1:0]    prod;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  dadda_mult #(.WIDTH(WIDTH)) dut (
    .opa  (opa),
    .opb  (opb),
    .prod (prod)
  );

  task automatic check(input string req, input logic [PW-1:0] got,
                       input logic [PW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s opa=%0d opb=%0d got=%0d exp=%0d", req, opa, opb, got, exp);
    end
  endtask

  task automatic apply(input int a, input int b);
    @(negedge clk);
    opa = WIDTH'(a);
    opb = WIDTH'(b);
    #1;
  endtask

  initial begin : watchdog
    #(8 * 180000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    opa = '0;
    opb = '0;
    #1;
    // R4: initial zero operands give zero at once
    check("R4", prod, '0);

    // R2: ladder of limits, floor of 1.5x starting at 2
    begin
      int e;
      e = 2;
      for (int k = 1; k <= 6; k++) begin
        check("R2", PW'(dadda_limit(k)), PW'(e));
        e = (e * 3) / 2;
      end
    end
    // R3: four stages with limits 6, 4, 3, 2 at width 8
    check("R3", PW'(dadda_stages(8)), PW'(4));
    check("R3", PW'(dadda_limit(4)), PW'(6));
    check("R3", PW'(dadda_limit(3)), PW'(4));

    // R1: exhaustive sweep against arithmetic reference
    for (int a = 0; a < (1 << WIDTH); a++) begin
      for (int b = 0; b < (1 << WIDTH); b++) begin
        apply(a, b);
        check("R1", prod, PW'(a * b));
      end
    end

    // R5: both operands all ones
    apply(255, 255);
    check("R5", prod, 16'hFE01);

    // R4: one zero operand with the other dense
    apply(0, 255);
    check("R4", prod, '0);
    apply(173, 0);
    check("R4", prod, '0);

    // R6: power-of-two operand acts as shift
    for (int k = 0; k < WIDTH; k++) begin
      apply(1 << k, 201);
      check("R6", prod, PW'(201) << k);
      apply(93, 1 << k);
      check("R6", prod, PW'(93) << k);
    end

    // R7: product follows operands with no clock edge between changes
    @(negedge clk);
    opa = 8'd17; opb = 8'd13; #0.5;
    check("R7", prod, PW'(221));
    opa = 8'd200; opb = 8'd3; #0.5;
    check("R7", prod, PW'(600));
    opa = 8'd17; opb = 8'd13; #0.5;
    check("R7", prod, PW'(221));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule